// File: doc/BRIEF.md
# Edge Interrupt Lazy-Mask Replay Unit

This unit sits on one interrupt line between the line and a CPU request output. In edge mode a software disable does not gate the line. It only sets a disabled flag and leaves the input live. An edge that then arrives is remembered as pending, and only at that moment is the line really masked. No request reaches the CPU. When software enables the line again, a pending edge comes back as one replayed request, so no edge is ever lost to the mask.

A configuration bit selects level mode instead. In level mode a disable masks at once and nothing is replayed: a level that rises and falls while masked leaves no trace. In edge mode a request stays up until it is acknowledged. An edge that arrives during that time is held in a single slot and is delivered after the acknowledge. The disabled, masked and pending bits are visible on status outputs.

Top module: `edge_replay_gate`

## Requirements
- R9: While reset is asserted, and right after it is released, `req`, `stat_disabled`, `stat_masked` and `stat_pending` are all 0.
- R7: `irq_in` passes through a two-flop synchronizer. An edge is a low-to-high change of the synchronized signal. In edge mode, if `irq_in` is first sampled high at rising edge k, `req` goes high after rising edge k+2.
- R1: In edge mode, `dis_stb` sets `stat_disabled` and leaves `stat_masked` at 0. An edge that arrives after that is still seen.
- R2: In edge mode, an edge seen while disabled and unmasked sets `stat_pending` and `stat_masked` in the same cycle and does not raise `req`.
- R3: `en_stb` clears `stat_disabled` and `stat_masked`. If `stat_pending` was 1, it is cleared and exactly one request is issued, visible on `req` one cycle after the strobe when no request is outstanding.
- R4: Any number of edges inside one disabled window leave a single pending bit and produce exactly one replayed request.
- R5: In edge mode, `req` stays high until `ack` is sampled high. An edge that arrives while `req` is high is held, and `req` stays high for the next request after that `ack`. Further edges in the same wait collapse into that one held request.
- R6: In level mode (`level_mode`=1), `dis_stb` sets both `stat_disabled` and `stat_masked` after the next rising edge. `req` equals the synchronized line gated by the mask, with no latching and no replay. A pulse seen only while masked gives no request after enable, and `stat_pending` stays 0.
- R8: A change of `level_mode` clears the pending bit, the held request and any edge-mode request. Masked becomes 1 only when entering level mode with the disabled flag set.
- R10: If `en_stb` and `dis_stb` are high in the same cycle, enable wins. `ack` while `req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Asynchronous interrupt line, active high |
| level_mode | input | 1 | 1 = level behaviour, 0 = edge behaviour with lazy mask and replay |
| dis_stb | input | 1 | One-cycle disable command |
| en_stb | input | 1 | One-cycle enable command |
| ack | input | 1 | CPU acknowledge of the current request |
| req | output | 1 | Interrupt request to the CPU |
| stat_disabled | output | 1 | Disabled flag |
| stat_masked | output | 1 | Line is really masked |
| stat_pending | output | 1 | An edge is waiting to be replayed |

## Verification
The hardest state to reach from the ports is one where two obligations overlap. A replay is owed because of a pending edge, and an edge is also held behind an unacknowledged request. On top of that, the trigger mode must change while the pending bit is set. The stimulus builds each of these on purpose. It raises a request and holds off `ack` while it pulses the line again. It disables the line, pulses it several times to collapse edges, and then either enables it or flips `level_mode`. A behavioural reference model runs beside the design and checks every cycle, so a wrong ordering shows up in the cycle where it happens.

// File: rtl/edge_replay_gate.sv
module edge_replay_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic level_mode,
  input  logic dis_stb,
  input  logic en_stb,
  input  logic ack,
  output logic req,
  output logic stat_disabled,
  output logic stat_masked,
  output logic stat_pending
);

  logic s1_q, s2_q, s3_q;
  logic mode_q;
  logic dis_q, mask_q, pend_q, held_q, req_q;

  logic edge_det, live, capture, deliver, mode_chg;

  assign edge_det = s2_q & ~s3_q;
  assign mode_chg = level_mode ^ mode_q;
  assign live     = edge_det & ~mask_q;
  assign capture  = live & dis_q & ~en_stb;
  assign deliver  = (live & ~(dis_q & ~en_stb)) | (en_stb & pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= irq_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      dis_q  <= 1'b0;
      mask_q <= 1'b0;
      pend_q <= 1'b0;
      held_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= level_mode;
      mask_q <= level_mode & dis_q;
      pend_q <= 1'b0;
      held_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (mode_q) begin
      if (en_stb) begin
        dis_q  <= 1'b0;
        mask_q <= 1'b0;
      end else if (dis_stb) begin
        dis_q  <= 1'b1;
        mask_q <= 1'b1;
      end
      pend_q <= 1'b0;
      held_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (en_stb)       dis_q <= 1'b0;
      else if (dis_stb) dis_q <= 1'b1;

      if (en_stb) begin
        mask_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (capture) begin
        mask_q <= 1'b1;
        pend_q <= 1'b1;
      end

      if (ack && req_q) begin
        req_q  <= held_q | deliver;
        held_q <= held_q & deliver;
      end else if (req_q) begin
        held_q <= held_q | deliver;
      end else begin
        req_q <= deliver;
      end
    end
  end

  assign req           = mode_q ? (s2_q & ~mask_q) : req_q;
  assign stat_disabled = dis_q;
  assign stat_masked   = mask_q;
  assign stat_pending  = pend_q;

  // R1
  lazy_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_stb && !en_stb && !level_mode && !mode_q && !mask_q && !edge_det) |=> !mask_q);

  // R2
  pend_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (mask_q && dis_q));

  // R3
  replay_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb && pend_q && !level_mode && !mode_q && !req_q) |=> (req_q && !pend_q));

  // R5
  held_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q |-> req_q);

  // R6
  level_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && level_mode) |=> !pend_q);

endmodule

// File: tb/edge_replay_gate_tb.sv
module edge_replay_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_in = 1'b0, level_mode = 1'b0, dis_stb = 1'b0, en_stb = 1'b0, ack = 1'b0;
  logic req, stat_disabled, stat_masked, stat_pending;

  int checks = 0;
  int failures = 0;
  string cur_req = "R9";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_replay_gate dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(level_mode),
    .dis_stb(dis_stb), .en_stb(en_stb), .ack(ack), .req(req),
    .stat_disabled(stat_disabled), .stat_masked(stat_masked), .stat_pending(stat_pending)
  );

  int hist[3];
  int m_mode, m_dis, m_mask, m_pend, m_held, m_rq;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (hist[i]) hist[i] = 0;
      m_mode = 0; m_dis = 0; m_mask = 0; m_pend = 0; m_held = 0; m_rq = 0;
    end else begin
      int rise, lv, cap, dlv, off;
      rise = (hist[1] == 1 && hist[2] == 0) ? 1 : 0;
      if (int'(level_mode) != m_mode) begin
        m_mode = int'(level_mode);
        m_mask = (m_mode == 1 && m_dis == 1) ? 1 : 0;
        m_pend = 0; m_held = 0; m_rq = 0;
      end else if (m_mode == 1) begin
        if (en_stb) m_dis = 0; else if (dis_stb) m_dis = 1;
        m_mask = m_dis;
        m_pend = 0; m_held = 0; m_rq = 0;
      end else begin
        lv  = (rise == 1 && m_mask == 0) ? 1 : 0;
        off = (m_dis == 1 && !en_stb) ? 1 : 0;
        cap = (lv == 1 && off == 1) ? 1 : 0;
        dlv = ((lv == 1 && off == 0) || (en_stb && m_pend == 1)) ? 1 : 0;
        if (en_stb) m_dis = 0; else if (dis_stb) m_dis = 1;
        if (en_stb) begin m_mask = 0; m_pend = 0; end
        else if (cap == 1) begin m_mask = 1; m_pend = 1; end
        if (ack && m_rq == 1) begin
          m_rq = (m_held == 1 || dlv == 1) ? 1 : 0;
          m_held = (m_held == 1 && dlv == 1) ? 1 : 0;
        end else if (m_rq == 1) begin
          if (dlv == 1) m_held = 1;
        end else m_rq = dlv;
      end
      hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = int'(irq_in);
    end
  end

  function automatic int exp_req();
    if (m_mode == 1) return (hist[1] == 1 && m_mask == 0) ? 1 : 0;
    return m_rq;
  endfunction

  task automatic chk(string tag, string what, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "model req", req, logic'(exp_req()));
      chk(cur_req, "model disabled", stat_disabled, logic'(m_dis));
      chk(cur_req, "model masked", stat_masked, logic'(m_mask));
      chk(cur_req, "model pending", stat_pending, logic'(m_pend));
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_irq();
    irq_in = 1'b1; cyc(1); irq_in = 1'b0; cyc(1);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R9", "req in reset", req, 1'b0);
    chk("R9", "pending in reset", stat_pending, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R9", "disabled after reset", stat_disabled, 1'b0);
    chk("R9", "masked after reset", stat_masked, 1'b0);

    cur_req = "R7";
    irq_in = 1'b1;
    cyc(2);
    chk("R7", "req not yet after k+1", req, 1'b0);
    cyc(1);
    chk("R7", "req after k+2", req, 1'b1);
    irq_in = 1'b0;
    cyc(2);
    strobe(ack);
    chk("R7", "req cleared by ack", req, 1'b0);

    cur_req = "R1";
    strobe(dis_stb);
    chk("R1", "disabled set", stat_disabled, 1'b1);
    chk("R1", "not masked", stat_masked, 1'b0);

    cur_req = "R2";
    pulse_irq();
    cyc(2);
    chk("R2", "pending", stat_pending, 1'b1);
    chk("R2", "masked", stat_masked, 1'b1);
    chk("R2", "no req", req, 1'b0);

    cur_req = "R4";
    pulse_irq(); pulse_irq(); cyc(3);
    chk("R4", "still one pending", stat_pending, 1'b1);

    cur_req = "R3";
    strobe(en_stb);
    chk("R3", "replayed req", req, 1'b1);
    chk("R3", "pending cleared", stat_pending, 1'b0);
    chk("R3", "unmasked", stat_masked, 1'b0);
    cyc(2);
    strobe(ack);
    cyc(3);
    chk("R4", "only one replay", req, 1'b0);

    cur_req = "R5";
    pulse_irq(); cyc(2);
    chk("R5", "first req", req, 1'b1);
    pulse_irq(); pulse_irq(); cyc(3);
    strobe(ack);
    chk("R5", "held edge delivered", req, 1'b1);
    strobe(ack);
    cyc(2);
    chk("R5", "collapsed, no third", req, 1'b0);

    cur_req = "R10";
    strobe(dis_stb);
    dis_stb = 1'b1; en_stb = 1'b1; cyc(1); dis_stb = 1'b0; en_stb = 1'b0;
    chk("R10", "enable wins", stat_disabled, 1'b0);
    strobe(ack);
    pulse_irq(); cyc(2);
    chk("R10", "ack w/o req ignored, edge still served", req, 1'b1);
    strobe(ack);
    cyc(1);

    cur_req = "R6";
    level_mode = 1'b1; cyc(2);
    irq_in = 1'b1; cyc(3);
    chk("R6", "level req follows line", req, 1'b1);
    strobe(dis_stb);
    chk("R6", "masked immediately", stat_masked, 1'b1);
    chk("R6", "req gated", req, 1'b0);
    irq_in = 1'b0; cyc(3);
    irq_in = 1'b1; cyc(3); irq_in = 1'b0; cyc(3);
    strobe(en_stb);
    cyc(2);
    chk("R6", "no replay in level mode", req, 1'b0);
    chk("R6", "no pending in level mode", stat_pending, 1'b0);

    cur_req = "R8";
    level_mode = 1'b0; cyc(2);
    strobe(dis_stb);
    pulse_irq(); cyc(2);
    chk("R8", "pending before switch", stat_pending, 1'b1);
    level_mode = 1'b1; cyc(1);
    chk("R8", "pending cleared by switch", stat_pending, 1'b0);
    chk("R8", "masked in level with disabled", stat_masked, 1'b1);
    level_mode = 1'b0; cyc(1);
    chk("R8", "unmasked back in edge", stat_masked, 1'b0);
    strobe(en_stb);
    cyc(2);
    chk("R8", "no replay after switch", req, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule